// File: doc/BRIEF.md
# Minimal accumulator ALU

This block is the arithmetic and logic unit of a very small accumulator machine meant to fit into a few programmable-logic cells. The accumulator is always the first operand. The second operand arrives already selected by one upstream multiplexer, for example a register or a constant. A 3-bit opcode picks one of eight operations. The 4-bit result is purely combinational. A two-bit status register captures carry and zero on a clock edge when the flag write enable is high.

Subtraction and increment share the single ripple adder. Subtraction feeds in the ones' complement of the second operand. Increment feeds in zero with a forced carry-in. A chain enable replaces the default carry-in with an external carry input. Wider arithmetic is then done word by word: the caller feeds the stored carry flag back into that input.

Top module: `mini_acc_alu`

## Requirements
- R1: Opcode 000 (ADD) gives result = acc + opnd + k, where k is carry_i when chain_en_i is 1 and 0 otherwise; the adder carry out goes to the carry flag.
- R2: Opcode 001 (SUB) gives result = acc + ~opnd + k, where k is carry_i when chain_en_i is 1 and 1 otherwise, so that without chaining result = acc - opnd; the stored carry is 1 exactly when no borrow occurred.
- R3: Opcodes 010 (AND), 011 (OR) and 100 (XOR) give the bitwise function of acc and opnd, and a flag write leaves the carry flag at its previous value.
- R4: Opcode 101 (ASR) shifts acc right by one place and keeps bit 3 at its old value; acc bit 0 goes to the carry flag; opnd has no effect.
- R5: Opcode 110 (ROL) rotates acc left by one place, so old bit 3 becomes bit 0; old bit 3 also goes to the carry flag; opnd has no effect.
- R6: Opcode 111 (INC) gives result = acc + k, where k is carry_i when chain_en_i is 1 and 1 otherwise; the carry out goes to the carry flag.
- R7: On every flag write, the zero flag becomes 1 exactly when the 4-bit result is 0000.
- R8: The flags change only on a rising clock edge with flags_we_i high; otherwise both hold. The result follows the inputs in the same cycle and does not depend on the flags.
- R9: An active-low reset clears both flags at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_i | input | 3 | Operation code |
| acc_i | input | 4 | Accumulator operand |
| opnd_i | input | 4 | Second operand from the source multiplexer |
| chain_en_i | input | 1 | Use carry_i as the adder carry-in |
| carry_i | input | 1 | External carry-in for chained arithmetic |
| flags_we_i | input | 1 | Flag write enable |
| result_o | output | 4 | Combinational result |
| carry_o | output | 1 | Stored carry flag |
| zero_o | output | 1 | Stored zero flag |

## Verification
Reading the carry flag and writing it can fall in the same cycle. This happens when a chained word takes its carry-in from carry_o and flags_we_i is high, so the flag is read and rewritten in one instruction. The bench provokes it with an 8-bit subtraction and an 8-bit addition done as two 4-bit steps, with carry_o wired back to carry_i. It checks that the upper word's result uses the old carry, while the new carry appears only after the edge. A second case runs a logic operation right after a carry-producing one, and checks that the carry written earlier survives the flag write.

// File: rtl/mini_alu_pkg.sv
package mini_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100,
        OP_ASR = 3'b101,
        OP_ROL = 3'b110,
        OP_INC = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic zero;
    } alu_flags_t;

    // Selects inside the bitwise unit
    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2
    } bw_sel_e;

    function automatic logic op_is_bitwise(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
    endfunction

endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    logic [WIDTH:0] c_chain;

    assign c_chain[0] = cin_i;

    // One full adder per bit, carries rippled upward
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic p_bit;
        logic g_bit_v;
        assign p_bit        = a_i[i] ^ b_i[i];
        assign g_bit_v      = a_i[i] & b_i[i];
        assign sum_o[i]     = p_bit ^ c_chain[i];
        assign c_chain[i+1] = g_bit_v | (p_bit & c_chain[i]);
    end

    assign cout_o = c_chain[WIDTH];
endmodule

// File: rtl/acc_bitwise.sv
module acc_bitwise
    import mini_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  bw_sel_e          sel_i,
    output logic [WIDTH-1:0] y_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (sel_i)
                BW_AND:  y_o[i] = a_i[i] & b_i[i];
                BW_OR:   y_o[i] = a_i[i] | b_i[i];
                default: y_o[i] = a_i[i] ^ b_i[i];
            endcase
        end
    end
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic             rol_i,
    output logic [WIDTH-1:0] y_o,
    output logic             out_bit_o
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        if (rol_i) begin
            y_o       = {a_i[MSB-1:0], a_i[MSB]};
            out_bit_o = a_i[MSB];
        end else begin
            y_o       = {a_i[MSB], a_i[MSB:1]};
            out_bit_o = a_i[0];
        end
    end
endmodule

// File: rtl/acc_flag_reg.sv
module acc_flag_reg
    import mini_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic       keep_carry_i,
    input  logic       carry_i,
    input  logic       zero_i,
    output alu_flags_t flags_o
);
    alu_flags_t flags_d;
    alu_flags_t flags_q;

    always_comb begin
        flags_d = flags_q;
        if (we_i) begin
            if (!keep_carry_i) begin
                flags_d.carry = carry_i;
            end
            flags_d.zero = zero_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

    // R8: without a write both flags hold across the edge
    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(flags_q));

    // R9: on the first edge after reset release both flags are clear
    p_reset_clear_r9: assert property (@(posedge clk)
        $rose(rst_n) |-> (flags_q == '0));
endmodule

// File: rtl/mini_acc_alu.sv
module mini_acc_alu
    import mini_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             chain_en_i,
    input  logic             carry_i,
    input  logic             flags_we_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             zero_o
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] add_b;
        logic             add_cin;
        bw_sel_e          bw_sel;
        logic             rol;
        logic [WIDTH-1:0] res;
        logic             carry;
        logic             keep_carry;
    } dp_t;

    alu_op_e          op;
    dp_t              dp_d;
    logic [WIDTH-1:0] sum_w;
    logic             cout_w;
    logic [WIDTH-1:0] bw_w;
    logic [WIDTH-1:0] sh_w;
    logic             sh_bit_w;
    alu_flags_t       flags_q;

    assign op = alu_op_e'(op_i);

    // Decode the adder inputs and pick the result and carry
    always_comb begin
        dp_d            = '0;
        dp_d.add_b      = opnd_i;
        dp_d.add_cin    = chain_en_i ? carry_i : 1'b0;
        dp_d.bw_sel     = BW_XOR;
        dp_d.rol        = (op == OP_ROL);
        dp_d.keep_carry = op_is_bitwise(op);
        unique case (op)
            OP_SUB: begin
                dp_d.add_b   = ~opnd_i;
                dp_d.add_cin = chain_en_i ? carry_i : 1'b1;
            end
            OP_INC: begin
                dp_d.add_b   = '0;
                dp_d.add_cin = chain_en_i ? carry_i : 1'b1;
            end
            OP_AND:  dp_d.bw_sel = BW_AND;
            OP_OR:   dp_d.bw_sel = BW_OR;
            default: ;
        endcase
    end

    acc_adder #(.WIDTH(WIDTH)) u_add (
        .a_i   (acc_i),
        .b_i   (dp_d.add_b),
        .cin_i (dp_d.add_cin),
        .sum_o (sum_w),
        .cout_o(cout_w)
    );

    acc_bitwise #(.WIDTH(WIDTH)) u_bw (
        .a_i  (acc_i),
        .b_i  (opnd_i),
        .sel_i(dp_d.bw_sel),
        .y_o  (bw_w)
    );

    acc_shifter #(.WIDTH(WIDTH)) u_sh (
        .a_i      (acc_i),
        .rol_i    (dp_d.rol),
        .y_o      (sh_w),
        .out_bit_o(sh_bit_w)
    );

    logic [WIDTH-1:0] res_w;
    logic             carry_w;

    always_comb begin
        if (op_is_arith(op)) begin
            res_w   = sum_w;
            carry_w = cout_w;
        end else if (op_is_bitwise(op)) begin
            res_w   = bw_w;
            carry_w = 1'b0;
        end else begin
            res_w   = sh_w;
            carry_w = sh_bit_w;
        end
    end

    acc_flag_reg u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (flags_we_i),
        .keep_carry_i(dp_d.keep_carry),
        .carry_i     (carry_w),
        .zero_i      (res_w == '0),
        .flags_o     (flags_q)
    );

    assign result_o = res_w;
    assign carry_o  = flags_q.carry;
    assign zero_o   = flags_q.zero;

    // R1: unchained add is plain modular addition
    p_add_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD && !chain_en_i) |-> (result_o == acc_i + opnd_i));

    // R2: unchained subtract is modular difference, carry means no borrow
    p_sub_diff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SUB && !chain_en_i) |-> (result_o == acc_i - opnd_i));
    p_sub_borrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we_i && op == OP_SUB && !chain_en_i)
        |=> (carry_o == ($past(acc_i) >= $past(opnd_i))));

    // R3: a bitwise operation leaves the carry flag alone
    p_logic_keeps_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we_i && op_is_bitwise(op)) |=> (carry_o == $past(carry_o)));

    // R4: arithmetic shift right keeps the sign
    p_asr_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ASR) |-> (result_o == $unsigned($signed(acc_i) >>> 1)));

    // R5: rotate left sends the old top bit to the carry
    p_rol_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we_i && op == OP_ROL) |=> (carry_o == $past(acc_i[MSB])));

    // R6: unchained increment adds one
    p_inc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC && !chain_en_i) |-> (result_o == acc_i + WIDTH'(1)));

    // R7: zero flag mirrors the written result
    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_i |=> (zero_o == ($past(result_o) == '0)));
endmodule

// File: tb/sim_mini_acc_alu.sv
module sim_mini_acc_alu;
    typedef struct packed {
        logic [2:0] op;
        logic [3:0] a;
        logic [3:0] b;
        logic       ch;
        logic       ci;
        logic [3:0] res;
        logic       c;
        logic       z;
    } vec_t;

    localparam int NV = 21;
    // Flags written on every vector, so carry expectations follow in order
    localparam vec_t VECS [NV] = '{
        '{3'b000, 4'h3, 4'h4, 1'b0, 1'b0, 4'h7, 1'b0, 1'b0},
        '{3'b000, 4'h9, 4'h7, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1},
        '{3'b000, 4'h5, 4'h5, 1'b1, 1'b1, 4'hB, 1'b0, 1'b0},
        '{3'b001, 4'h7, 4'h3, 1'b0, 1'b0, 4'h4, 1'b1, 1'b0},
        '{3'b001, 4'h3, 4'h7, 1'b0, 1'b0, 4'hC, 1'b0, 1'b0},
        '{3'b001, 4'h5, 4'h5, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1},
        '{3'b001, 4'h6, 4'h2, 1'b1, 1'b0, 4'h3, 1'b1, 1'b0},
        '{3'b010, 4'hC, 4'hA, 1'b0, 1'b0, 4'h8, 1'b1, 1'b0},
        '{3'b011, 4'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1},
        '{3'b100, 4'hF, 4'hF, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1},
        '{3'b101, 4'h9, 4'hF, 1'b0, 1'b0, 4'hC, 1'b1, 1'b0},
        '{3'b101, 4'h6, 4'h5, 1'b0, 1'b0, 4'h3, 1'b0, 1'b0},
        '{3'b100, 4'h5, 4'h3, 1'b0, 1'b0, 4'h6, 1'b0, 1'b0},
        '{3'b110, 4'hA, 4'hF, 1'b0, 1'b0, 4'h5, 1'b1, 1'b0},
        '{3'b110, 4'h4, 4'h7, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0},
        '{3'b111, 4'hF, 4'h9, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1},
        '{3'b111, 4'h7, 4'h0, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0},
        '{3'b111, 4'h5, 4'h0, 1'b1, 1'b0, 4'h5, 1'b0, 1'b0},
        '{3'b010, 4'hF, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1},
        '{3'b000, 4'hF, 4'hF, 1'b1, 1'b1, 4'hF, 1'b1, 1'b0},
        '{3'b011, 4'h1, 4'h2, 1'b0, 1'b0, 4'h3, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op = '0;
    logic [3:0] acc = '0;
    logic [3:0] opnd = '0;
    logic       chain_en = 1'b0;
    logic       cin = 1'b0;
    logic       we = 1'b0;
    logic [3:0] result;
    logic       carry;
    logic       zero;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mini_acc_alu u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .acc_i     (acc),
        .opnd_i    (opnd),
        .chain_en_i(chain_en),
        .carry_i   (cin),
        .flags_we_i(we),
        .result_o  (result),
        .carry_o   (carry),
        .zero_o    (zero)
    );

    function automatic string op_tag(logic [2:0] o);
        case (o)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b101:  return "R4";
            3'b110:  return "R5";
            3'b111:  return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [2:0] o, logic [3:0] a, logic [3:0] b,
                         logic ch, logic ci, logic w);
        @(negedge clk);
        op = o; acc = a; opnd = b; chain_en = ch; cin = ci; we = w;
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R9", "carry in reset", int'(carry), 0);
        check("R9", "zero in reset", int'(zero), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].ch, VECS[i].ci, 1'b1);
            check(op_tag(VECS[i].op), "result", int'(result), int'(VECS[i].res));
            @(posedge clk);
            #1;
            check(op_tag(VECS[i].op), "carry flag", int'(carry), int'(VECS[i].c));
            check("R7", "zero flag", int'(zero), int'(VECS[i].z));
        end

        // R8: no write -> flags hold; result still live. State now c=1 z=0
        drive(3'b001, 4'h5, 4'h5, 1'b0, 1'b0, 1'b0);
        check("R8", "result without write", int'(result), 0);
        @(posedge clk);
        #1;
        check("R8", "carry held", int'(carry), 1);
        check("R8", "zero held", int'(zero), 0);
        // R8: result ignores stored flags (carry=1 stored, chain off)
        drive(3'b000, 4'h2, 4'h3, 1'b0, 1'b0, 1'b0);
        check("R8", "result independent of flags", int'(result), 5);

        // R2 chained: 0x52 - 0x37 = 0x1B, carry_o fed back to carry_i
        drive(3'b001, 4'h2, 4'h7, 1'b0, 1'b0, 1'b1);
        check("R2", "low word diff", int'(result), 4'hB);
        @(posedge clk);
        #1;
        check("R2", "low word borrow", int'(carry), 0);
        drive(3'b001, 4'h5, 4'h3, 1'b1, carry, 1'b1);
        check("R2", "high word uses old carry", int'(result), 4'h1);
        check("R2", "carry not yet updated", int'(carry), 0);
        @(posedge clk);
        #1;
        check("R2", "high word no borrow", int'(carry), 1);

        // R1 chained: 0x9C + 0x25 = 0xC1
        drive(3'b000, 4'hC, 4'h5, 1'b0, 1'b0, 1'b1);
        check("R1", "low word sum", int'(result), 4'h1);
        @(posedge clk);
        #1;
        check("R1", "low word carry", int'(carry), 1);
        drive(3'b000, 4'h9, 4'h2, 1'b1, carry, 1'b1);
        check("R1", "high word with carry", int'(result), 4'hC);
        @(posedge clk);
        #1;
        check("R1", "high word carry out", int'(carry), 0);

        // R3: logic right after a carry-producing op keeps carry
        drive(3'b111, 4'hF, 4'h0, 1'b0, 1'b0, 1'b1);
        @(posedge clk);
        drive(3'b100, 4'h3, 4'h3, 1'b0, 1'b0, 1'b1);
        @(posedge clk);
        #1;
        check("R3", "carry survives XOR", int'(carry), 1);
        check("R7", "zero after XOR", int'(zero), 1);

        // R4/R5: second operand has no effect
        drive(3'b101, 4'h8, 4'h0, 1'b0, 1'b0, 1'b0);
        check("R4", "ASR ignores opnd 0", int'(result), 4'hC);
        drive(3'b101, 4'h8, 4'hF, 1'b0, 1'b0, 1'b0);
        check("R4", "ASR ignores opnd F", int'(result), 4'hC);
        drive(3'b110, 4'h9, 4'h6, 1'b0, 1'b0, 1'b0);
        check("R5", "ROL ignores opnd", int'(result), 4'h3);

        // R9: asynchronous reset mid-run clears flags before any edge
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", "carry cleared async", int'(carry), 0);
        check("R9", "zero cleared async", int'(zero), 0);
        @(negedge clk);
        rst_n = 1'b1;
        we = 1'b0;
        @(posedge clk);
        #1;
        check("R9", "carry after release", int'(carry), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule